// File: doc/BRIEF.md
# Lockable Clock Mode Control Register

This block holds the eight-bit clock mode word of a small microcontroller and turns it into the control levels that the clock tree reads. Software writes the word through a synchronous port with a data bus and a write strobe. The block then applies two kinds of correction. A lock input freezes the bits that change the clock source. Hardware rules force some bits high on their own, either when a stop-mode entry strobe arrives or when certain bit combinations would leave the clock tree in an unsafe setting.

The outputs give the value of each field. Bit 2 stops the peripheral clock f1 while the core sleeps. The sub-oscillator drive strength, the pin select for the sub-oscillator, the main-clock stop request and the divide-by-8 select each follow their own bit. A two-bit CPU clock source code comes from bit 7 together with an external selector. Bit 2 acts on f1 only. The sub clock and the on-chip oscillator outputs never depend on it. Bit 5 is a stop request and gives no status. A pulse flags any attempt to set the lock while the sub clock drives the CPU.

Top module: `clkmode_ctl`

## Requirements
- R1: After reset the register reads 0x08, `lock_err` and `per_gate_off` are 0, and `sub_drive_hi` is 1.
- R2: Bits 1 and 0 always read 0, and writes to them have no effect.
- R3: While `lock` is 0, a write (`wr_en`=1) loads bits 2, 4, 5 and 7 from `wr_data`, and bits 3 and 6 too unless a force rule applies. `rd_data` shows the new value in the cycle after the write edge.
- R4: While `lock` is 1, a write leaves bits 2, 5 and 7 unchanged. The other writable bits are still loaded.
- R5: Bit 3 (sub-oscillator drive, 1 = high) reads 1 whenever bit 4 (1 = pins used by the sub-oscillator, 0 = pins used as I/O) is 0, even when 0 is written to bit 3.
- R6: A `stop_entry` pulse sets bits 3 and 6 to 1 at the same edge. This overrides write data for those bits in the same cycle.
- R7: Bit 6 (1 = main clock divided by 8) reads 1 whenever bit 7 and bit 5 are both 1.
- R8: `cpu_src` is 3 (sub clock) when bit 7 is 1. When bit 7 is 0, `cpu_src` follows `src_sel`: 00 gives 0 (main), 01 gives 1 (PLL), and 10 or 11 give 2 (on-chip oscillator).
- R9: `per_gate_off` is 1 only while bit 2 is 1 and the sleep state is active. The sleep state sets at the edge after a `wait_entry` pulse and clears at the edge after a `resume` pulse. `wait_entry` wins if both pulses arrive together.
- R10: `lock_err` is 1 for exactly one cycle. It rises in the cycle after the first edge at which `lock` is sampled 1 (it was 0 at the previous edge) while bit 7 is 1.
- R11: `sub_drive_hi`, `xc_osc_sel`, `main_stop_req` and `main_div8` equal bits 3, 4, 5 and 6 of the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| lock | input | 1 | Clock-change lock |
| stop_entry | input | 1 | Stop-mode entry strobe |
| wait_entry | input | 1 | Wait-mode entry strobe |
| resume | input | 1 | Wake from wait mode |
| src_sel | input | 2 | Clock source chosen when bit 7 is 0 |
| rd_data | output | 8 | Current register value |
| per_gate_off | output | 1 | Gate peripheral clock f1 off |
| sub_drive_hi | output | 1 | Sub-oscillator high drive |
| xc_osc_sel | output | 1 | Pins used by the sub-oscillator |
| main_stop_req | output | 1 | Main clock stop request |
| main_div8 | output | 1 | Main clock divide-by-8 |
| cpu_src | output | 2 | CPU clock source code |
| lock_err | output | 1 | Lock requested while bit 7 set |

## Verification
The bench targets these corner cases:
- A write that clears bit 3 while bit 4 is 0 must still read back 1 for bit 3. A design that lets the write win would show a low drive strength on pins that serve as ports.
- A stop strobe that arrives together with a write must win. A design with the wrong priority would keep the written zeros in bits 3 and 6.
- A write under lock must still move the unlocked bits. A design whose mask covers the whole word would freeze bit 4.
- A design that took the clock source from the old value of bit 7 would report the wrong CPU clock source.
- A design that sets `lock_err` while the lock stays high, rather than on the first cycle the lock is seen, would flag repeatedly. A design that never checks bit 7 would flag a legal lock.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;
   localparam int REG_W    = 8;
   localparam int B_F1STOP = 2;
   localparam int B_DRIVE  = 3;
   localparam int B_PINSEL = 4;
   localparam int B_MSTOP  = 5;
   localparam int B_DIV8   = 6;
   localparam int B_SYSSEL = 7;

   typedef enum logic [1:0] {
      SRC_MAIN   = 2'd0,
      SRC_PLL    = 2'd1,
      SRC_ONCHIP = 2'd2,
      SRC_SUB    = 2'd3
   } cpu_src_t;
endpackage

// File: rtl/clkmode_wmask.sv
// Per-bit write staging: reserved bits read zero, lockable bits hold under lock.
module clkmode_wmask #(
   parameter int            W         = 8,
   parameter logic [W-1:0]  LOCK_MASK = 8'hA4,
   parameter logic [W-1:0]  IMPL_MASK = 8'hFC
) (
   input  logic [W-1:0] cur,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   input  logic         lock,
   output logic [W-1:0] staged
);
   logic unused_rsv;
   assign unused_rsv = ^(wr_data & ~IMPL_MASK) ^ ^(cur & ~IMPL_MASK);

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (!IMPL_MASK[i]) begin : g_rsv
         assign staged[i] = 1'b0;
      end else if (LOCK_MASK[i]) begin : g_lockable
         assign staged[i] = (wr_en && !lock) ? wr_data[i] : cur[i];
      end else begin : g_plain
         assign staged[i] = wr_en ? wr_data[i] : cur[i];
      end
   end
endmodule

// File: rtl/clkmode_force.sv
// Hardware force rules applied on top of the staged write value.
module clkmode_force
   import clkmode_pkg::*;
(
   input  logic [REG_W-1:0] staged,
   input  logic             stop_entry,
   output logic [REG_W-1:0] nxt
);
   always_comb begin
      nxt = staged;
      if (stop_entry || !staged[B_PINSEL])
         nxt[B_DRIVE] = 1'b1;
      if (stop_entry || (staged[B_SYSSEL] && staged[B_MSTOP]))
         nxt[B_DIV8] = 1'b1;
   end
endmodule

// File: rtl/clkmode_srcsel.sv
// CPU clock source code from the system select bit and the external selector.
module clkmode_srcsel
   import clkmode_pkg::*;
#(
   parameter int SEL_W = 2
) (
   input  logic             sys_sub,
   input  logic [SEL_W-1:0] src_sel,
   output cpu_src_t         src
);
   always_comb begin
      if (sys_sub)
         src = SRC_SUB;
      else if (src_sel == SEL_W'(0))
         src = SRC_MAIN;
      else if (src_sel == SEL_W'(1))
         src = SRC_PLL;
      else
         src = SRC_ONCHIP;
   end
endmodule

// File: rtl/clkmode_ctl.sv
module clkmode_ctl
   import clkmode_pkg::*;
#(
   parameter logic [REG_W-1:0] RESET_VAL = 8'h08,
   parameter logic [REG_W-1:0] LOCK_MASK = 8'hA4,
   parameter logic [REG_W-1:0] IMPL_MASK = 8'hFC,
   parameter int               SEL_W     = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   input  logic             lock,
   input  logic             stop_entry,
   input  logic             wait_entry,
   input  logic             resume,
   input  logic [SEL_W-1:0] src_sel,
   output logic [REG_W-1:0] rd_data,
   output logic             per_gate_off,
   output logic             sub_drive_hi,
   output logic             xc_osc_sel,
   output logic             main_stop_req,
   output logic             main_div8,
   output logic [1:0]       cpu_src,
   output logic             lock_err
);
   if (!RESET_VAL[B_PINSEL] && !RESET_VAL[B_DRIVE]) begin : g_bad_reset
      initial $fatal(1, "RESET_VAL violates the drive force rule");
   end
   if ((RESET_VAL & ~IMPL_MASK) != '0) begin : g_bad_rsv
      initial $fatal(1, "RESET_VAL sets reserved bits");
   end
   if (SEL_W < 2) begin : g_bad_sel
      initial $fatal(1, "SEL_W must be at least 2");
   end

   logic [REG_W-1:0] mode_q, staged, nxt;
   logic             sleeping_q, lock_q, lock_err_q;
   cpu_src_t         src;

   clkmode_wmask #(
      .W(REG_W), .LOCK_MASK(LOCK_MASK), .IMPL_MASK(IMPL_MASK)
   ) u_wmask (
      .cur(mode_q), .wr_en(wr_en), .wr_data(wr_data), .lock(lock), .staged(staged)
   );

   clkmode_force u_force (
      .staged(staged), .stop_entry(stop_entry), .nxt(nxt)
   );

   clkmode_srcsel #(.SEL_W(SEL_W)) u_src (
      .sys_sub(mode_q[B_SYSSEL]), .src_sel(src_sel), .src(src)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q     <= RESET_VAL;
         sleeping_q <= 1'b0;
         lock_q     <= 1'b0;
         lock_err_q <= 1'b0;
      end else begin
         mode_q     <= nxt;
         sleeping_q <= wait_entry | (sleeping_q & ~resume);
         lock_q     <= lock;
         lock_err_q <= lock & ~lock_q & mode_q[B_SYSSEL];
      end
   end

   assign rd_data       = mode_q;
   assign per_gate_off  = mode_q[B_F1STOP] & sleeping_q;
   assign sub_drive_hi  = mode_q[B_DRIVE];
   assign xc_osc_sel    = mode_q[B_PINSEL];
   assign main_stop_req = mode_q[B_MSTOP];
   assign main_div8     = mode_q[B_DIV8];
   assign cpu_src       = src;
   assign lock_err      = lock_err_q;
endmodule

// File: rtl/clkmode_ctl_chk.sv
module clkmode_ctl_chk #(
   parameter logic [7:0] LOCK_MASK = 8'hA4
) (
   input logic       clk,
   input logic       rst_n,
   input logic       lock,
   input logic       stop_entry,
   input logic [7:0] rd_data,
   input logic       per_gate_off,
   input logic [1:0] cpu_src,
   input logic       lock_err
);
   // R2
   rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[1:0] == 2'b00);
   // R4
   locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock |=> $stable(rd_data & LOCK_MASK));
   // R5
   drive_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_data[4] |-> rd_data[3]);
   // R6
   stop_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_entry |=> (rd_data[3] && rd_data[6]));
   // R7
   div8_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[7] && rd_data[5]) |-> rd_data[6]);
   // R8
   sub_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[7] |-> (cpu_src == 2'd3));
   // R8
   main_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_data[7] |-> (cpu_src != 2'd3));
   // R9
   gate_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      per_gate_off |-> rd_data[2]);
   // R10
   lock_err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock_err |-> ($past(lock) && $past(rd_data[7])));
endmodule

bind clkmode_ctl clkmode_ctl_chk #(.LOCK_MASK(LOCK_MASK)) u_chk (
   .clk(clk), .rst_n(rst_n), .lock(lock), .stop_entry(stop_entry),
   .rd_data(rd_data), .per_gate_off(per_gate_off), .cpu_src(cpu_src),
   .lock_err(lock_err)
);

// File: tb/tb_clkmode_ctl.sv
`timescale 1ns/1ps
module tb_clkmode_ctl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       lock = 1'b0;
   logic       stop_entry = 1'b0;
   logic       wait_entry = 1'b0;
   logic       resume = 1'b0;
   logic [1:0] src_sel = 2'b00;
   logic [7:0] rd_data;
   logic       per_gate_off, sub_drive_hi, xc_osc_sel, main_stop_req, main_div8, lock_err;
   logic [1:0] cpu_src;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   clkmode_ctl dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .lock(lock),
      .stop_entry(stop_entry), .wait_entry(wait_entry), .resume(resume),
      .src_sel(src_sel), .rd_data(rd_data), .per_gate_off(per_gate_off),
      .sub_drive_hi(sub_drive_hi), .xc_osc_sel(xc_osc_sel),
      .main_stop_req(main_stop_req), .main_div8(main_div8),
      .cpu_src(cpu_src), .lock_err(lock_err)
   );

   // Vector: {lock, write data, expected read value}
   localparam int NV = 10;
   localparam logic [16:0] VEC [NV] = '{
      {1'b0, 8'hFF, 8'hFC},   // R2 R3 R7
      {1'b0, 8'h10, 8'h10},   // R3
      {1'b0, 8'h00, 8'h08},   // R5
      {1'b0, 8'h30, 8'h30},   // R3
      {1'b0, 8'hA0, 8'hE8},   // R5 R7
      {1'b0, 8'h24, 8'h2C},   // R5
      {1'b1, 8'h90, 8'h34},   // R4
      {1'b1, 8'h00, 8'h2C},   // R4 R5
      {1'b0, 8'hD3, 8'hD0},   // R2 R3
      {1'b0, 8'h90, 8'h90}    // R3
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] d);
      wr_en = 1'b1; wr_data = d;
      step();
      wr_en = 1'b0;
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset value", rd_data, 8'h08);
      chk("R1 lock_err", {7'd0, lock_err}, 8'h00);
      chk("R1 per_gate_off", {7'd0, per_gate_off}, 8'h00);
      rst_n = 1'b1;
      step();
      chk("R1 held after reset", rd_data, 8'h08);
      chk("R11 sub_drive_hi", {7'd0, sub_drive_hi}, 8'h01);
      chk("R8 main source", {6'd0, cpu_src}, 8'h00);

      for (int i = 0; i < NV; i++) begin
         lock = VEC[i][16];
         wr(VEC[i][15:8]);
         chk($sformatf("R3/R4 vector %0d", i), rd_data, VEC[i][7:0]);
      end
      lock = 1'b0;
      step();
      chk("R10 no error for legal lock", {7'd0, lock_err}, 8'h00);

      // R6 stop entry overrides write in the same cycle
      wr_en = 1'b1; wr_data = 8'h10; stop_entry = 1'b1;
      step();
      wr_en = 1'b0; stop_entry = 1'b0;
      chk("R6 stop forces bits 3,6", rd_data, 8'h58);
      chk("R11 outputs", {4'd0, main_div8, main_stop_req, xc_osc_sel, sub_drive_hi}, 8'h0B);

      // R7 combination force
      wr(8'hB0);
      chk("R7 sub clock and main stop", rd_data, 8'hF0);
      chk("R11 main_div8", {7'd0, main_div8}, 8'h01);

      // R8 source select
      for (int s = 0; s < 4; s++) begin
         src_sel = 2'(s);
         #1;
         chk("R8 sub overrides selector", {6'd0, cpu_src}, 8'h03);
      end
      wr(8'h10);
      for (int s = 0; s < 4; s++) begin
         src_sel = 2'(s);
         #1;
         chk($sformatf("R8 selector %0d", s), {6'd0, cpu_src}, (s >= 2) ? 8'h02 : 8'(s));
      end
      src_sel = 2'b00;

      // R10 lock request while bit 7 set
      wr(8'h90);
      lock = 1'b1;
      step();
      chk("R10 lock_err pulse", {7'd0, lock_err}, 8'h01);
      step();
      chk("R10 lock_err one cycle", {7'd0, lock_err}, 8'h00);
      chk("R4 bit 7 held", rd_data, 8'h90);
      lock = 1'b0;
      wr(8'h10);
      lock = 1'b1;
      step();
      chk("R10 no error with bit 7 clear", {7'd0, lock_err}, 8'h00);
      lock = 1'b0;

      // R9 wait gating
      wr(8'h14);
      chk("R9 no gate when awake", {7'd0, per_gate_off}, 8'h00);
      wait_entry = 1'b1; step(); wait_entry = 1'b0;
      chk("R9 gate in wait", {7'd0, per_gate_off}, 8'h01);
      resume = 1'b1; wait_entry = 1'b1; step(); resume = 1'b0; wait_entry = 1'b0;
      chk("R9 wait wins over resume", {7'd0, per_gate_off}, 8'h01);
      resume = 1'b1; step(); resume = 1'b0;
      chk("R9 gate released", {7'd0, per_gate_off}, 8'h00);
      wr(8'h10);
      wait_entry = 1'b1; step(); wait_entry = 1'b0;
      chk("R9 bit 2 clear no gate", {7'd0, per_gate_off}, 8'h00);

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule